// File: doc/BRIEF.md
# Register Ready and Producer Table

This block tracks, for every architectural register of an out-of-order core, whether its value is available yet. When it is not, the block also records which in-flight instruction will produce it. Each entry holds one ready flag and the tag of the most recent instruction that claimed the register as its destination. Register values are not held here.

In each cycle the dispatch stage offers a group of up to `GROUP` instructions, listed oldest first. Each instruction may read two source registers. For each source the table answers either "ready" or "waiting on tag T". It then records every instruction that has a destination as that register's new producer.

A completion port with `CMP` lanes returns finished instructions. A completion marks its register ready only if the completing tag is still the newest producer recorded for that register. This stops an older writer from freeing a register that a younger writer has already claimed. Lookups inside a dispatch group see the claims of older group members, and they also see completions arriving in the same cycle.

Top module: `reg_ready_table`

## Requirements
- R1: After reset every one of the `NREG` entries is ready, so a lookup of any register returns ready with tag 0.
- R2: A source whose enable bit is 0 (no operand) always returns ready with tag 0, whatever its index.
- R3: A lookup of a register that is not ready, with no override from R7 or R10, returns not ready and the register's recorded producer tag. A ready result always carries tag 0.
- R4: A valid dispatch with its destination enabled clears that register's ready flag and stores the instruction's tag as producer, and lookups see this from the next cycle on.
- R5: A valid completion whose tag equals the register's recorded producer makes the register ready from the next cycle.
- R6: A completion whose tag differs from the recorded producer changes neither the ready flag nor the tag.
- R7: A source in group slot g whose register is the destination of an older valid slot in the same group (lower slot number) returns not ready with the nearest such older slot's tag.
- R8: When several slots of one group write the same register, the youngest (highest slot number) becomes its recorded producer.
- R9: When a completion and a dispatch target the same register in one cycle, the dispatch wins: the register is not ready afterwards and holds the dispatching tag.
- R10: A source whose register has a matching completion (per R5) in the same cycle returns ready, unless an older group slot claims that register (R7).
- R11: A slot's sources never see its own destination claim; they return the state from before that slot.
- R12: A dispatch slot with its valid bit at 0 leaves the table unchanged, even with its destination enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | GROUP | Slot g holds an instruction (bit g; slot 0 is oldest) |
| disp_dst_en | input | GROUP | Slot g has a destination register |
| disp_dst | input | GROUP*IW | Destination index of slot g at bits [g*IW +: IW] |
| disp_tag | input | GROUP*TAG_W | Tag of slot g at bits [g*TAG_W +: TAG_W] |
| src_en | input | GROUP*2 | Source k = 2*g+s of slot g is present |
| src_idx | input | GROUP*2*IW | Register index of source k at bits [k*IW +: IW] |
| src_ready | output | GROUP*2 | Source k is available |
| src_tag | output | GROUP*2*TAG_W | Producer tag of source k, 0 when ready |
| cmp_valid | input | CMP | Completion lane c is active |
| cmp_reg | input | CMP*IW | Destination register of lane c |
| cmp_tag | input | CMP*TAG_W | Tag of the completing instruction on lane c |

## Verification
The assertions check on every cycle the rules that depend only on a single step. An absent operand reads ready. The youngest claim lands in the table. A matching completion releases its register, and a stale completion leaves its register untouched. A same-cycle dispatch overrides a completion. Slot 1 sees slot 0's claim. Reset state over all registers, same-cycle completion visibility, and multi-step histories can only be shown by the bench. Those histories are claims superseded before their completions arrive, and tag chains across many cycles. The bench covers them with an exhaustive register sweep, directed sequences and a long pseudo-random run over a few colliding registers.

// File: rtl/reg_ready_table.sv
module reg_ready_table #(
  parameter int NREG  = 128,
  parameter int TAG_W = 8,
  parameter int GROUP = 2,
  parameter int CMP   = 2,
  localparam int IW   = $clog2(NREG),
  localparam int NSRC = GROUP * 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [GROUP-1:0]        disp_valid,
  input  logic [GROUP-1:0]        disp_dst_en,
  input  logic [GROUP*IW-1:0]     disp_dst,
  input  logic [GROUP*TAG_W-1:0]  disp_tag,
  input  logic [NSRC-1:0]         src_en,
  input  logic [NSRC*IW-1:0]      src_idx,
  output logic [NSRC-1:0]         src_ready,
  output logic [NSRC*TAG_W-1:0]   src_tag,
  input  logic [CMP-1:0]          cmp_valid,
  input  logic [CMP*IW-1:0]       cmp_reg,
  input  logic [CMP*TAG_W-1:0]    cmp_tag
);

  logic             rdy_q [NREG];
  logic [TAG_W-1:0] tag_q [NREG];

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    logic [IW-1:0]    idx;
    logic             r;
    logic [TAG_W-1:0] t;
    assign idx = src_idx[k*IW +: IW];

    always_comb begin
      r = rdy_q[idx];
      t = tag_q[idx];
      for (int c = 0; c < CMP; c++)
        if (cmp_valid[c] && cmp_reg[c*IW +: IW] == idx && cmp_tag[c*TAG_W +: TAG_W] == tag_q[idx])
          r = 1'b1;
      for (int o = 0; o < k / 2; o++)
        if (disp_valid[o] && disp_dst_en[o] && disp_dst[o*IW +: IW] == idx) begin
          r = 1'b0;
          t = disp_tag[o*TAG_W +: TAG_W];
        end
      if (!src_en[k]) r = 1'b1;
      if (r) t = '0;
    end

    assign src_ready[k]               = r;
    assign src_tag[k*TAG_W +: TAG_W]  = t;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        rdy_q[i] <= 1'b1;
        tag_q[i] <= '0;
      end
    end else begin
      for (int c = 0; c < CMP; c++)
        if (cmp_valid[c] && tag_q[cmp_reg[c*IW +: IW]] == cmp_tag[c*TAG_W +: TAG_W])
          rdy_q[cmp_reg[c*IW +: IW]] <= 1'b1;
      for (int g = 0; g < GROUP; g++)
        if (disp_valid[g] && disp_dst_en[g]) begin
          rdy_q[disp_dst[g*IW +: IW]] <= 1'b0;
          tag_q[disp_dst[g*IW +: IW]] <= disp_tag[g*TAG_W +: TAG_W];
        end
    end
  end

endmodule

// File: rtl/reg_ready_table_chk.sv
module reg_ready_table_chk #(
  parameter int NREG  = 128,
  parameter int TAG_W = 8,
  parameter int GROUP = 2,
  parameter int CMP   = 2,
  localparam int IW   = $clog2(NREG),
  localparam int NSRC = GROUP * 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [GROUP-1:0]        disp_valid,
  input logic [GROUP-1:0]        disp_dst_en,
  input logic [GROUP*IW-1:0]     disp_dst,
  input logic [GROUP*TAG_W-1:0]  disp_tag,
  input logic [NSRC-1:0]         src_en,
  input logic [NSRC*IW-1:0]      src_idx,
  input logic [NSRC-1:0]         src_ready,
  input logic [NSRC*TAG_W-1:0]   src_tag,
  input logic [CMP-1:0]          cmp_valid,
  input logic [CMP*IW-1:0]       cmp_reg,
  input logic [CMP*TAG_W-1:0]    cmp_tag,
  input logic                    rdy_q [NREG],
  input logic [TAG_W-1:0]        tag_q [NREG]
);

  logic [IW-1:0]    r0, ylast_dst;
  logic [TAG_W-1:0] t0, ylast_tag;
  logic             claim0, claim_last, match0, other_match;
  assign r0        = cmp_reg[IW-1:0];
  assign t0        = cmp_tag[TAG_W-1:0];
  assign ylast_dst = disp_dst[(GROUP-1)*IW +: IW];
  assign ylast_tag = disp_tag[(GROUP-1)*TAG_W +: TAG_W];
  assign claim_last = disp_valid[GROUP-1] && disp_dst_en[GROUP-1];
  assign match0    = cmp_valid[0] && tag_q[r0] == t0;

  always_comb begin
    claim0 = 1'b0;
    for (int g = 0; g < GROUP; g++)
      if (disp_valid[g] && disp_dst_en[g] && disp_dst[g*IW +: IW] == r0) claim0 = 1'b1;
    other_match = 1'b0;
    for (int c = 1; c < CMP; c++)
      if (cmp_valid[c] && cmp_reg[c*IW +: IW] == r0 && cmp_tag[c*TAG_W +: TAG_W] == tag_q[r0])
        other_match = 1'b1;
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_nosrc
    AST_ABSENT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !src_en[k] |-> src_ready[k] && src_tag[k*TAG_W +: TAG_W] == '0); // R2
  end

  AST_YOUNGEST_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    claim_last |=> !rdy_q[$past(ylast_dst)] && tag_q[$past(ylast_dst)] == $past(ylast_tag)); // R8

  AST_MATCH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    match0 && !claim0 |=> rdy_q[$past(r0)]); // R5

  AST_STALE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid[0] && !rdy_q[r0] && tag_q[r0] != t0 && !claim0 && !other_match
    |=> !rdy_q[$past(r0)] && tag_q[$past(r0)] == $past(tag_q[r0])); // R6

  AST_DISPATCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid[0] && claim0 |=> !rdy_q[$past(r0)]); // R9

  if (GROUP > 1) begin : g_byp
    AST_GROUP_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid[0] && disp_dst_en[0] && src_en[2] && src_idx[2*IW +: IW] == disp_dst[IW-1:0]
      |-> !src_ready[2] && src_tag[2*TAG_W +: TAG_W] == disp_tag[TAG_W-1:0]); // R7
  end

endmodule

bind reg_ready_table reg_ready_table_chk #(
  .NREG(NREG), .TAG_W(TAG_W), .GROUP(GROUP), .CMP(CMP)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .disp_valid(disp_valid), .disp_dst_en(disp_dst_en), .disp_dst(disp_dst), .disp_tag(disp_tag),
  .src_en(src_en), .src_idx(src_idx), .src_ready(src_ready), .src_tag(src_tag),
  .cmp_valid(cmp_valid), .cmp_reg(cmp_reg), .cmp_tag(cmp_tag),
  .rdy_q(rdy_q), .tag_q(tag_q)
);

// File: tb/reg_ready_table_tb.sv
module reg_ready_table_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NREG = 128, TAG_W = 8, GROUP = 2, CMP = 2;
  localparam int IW = $clog2(NREG), NSRC = GROUP * 2;

  logic clk = 0, rst_n = 0;
  logic [GROUP-1:0] disp_valid, disp_dst_en;
  logic [GROUP*IW-1:0] disp_dst;
  logic [GROUP*TAG_W-1:0] disp_tag;
  logic [NSRC-1:0] src_en, src_ready;
  logic [NSRC*IW-1:0] src_idx;
  logic [NSRC*TAG_W-1:0] src_tag;
  logic [CMP-1:0] cmp_valid;
  logic [CMP*IW-1:0] cmp_reg;
  logic [CMP*TAG_W-1:0] cmp_tag;

  always #2.5 clk = ~clk;

  reg_ready_table #(.NREG(NREG), .TAG_W(TAG_W), .GROUP(GROUP), .CMP(CMP)) u_dut (.*);

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  bit m_rdy [NREG];
  logic [TAG_W-1:0] m_tag [NREG];
  logic [TAG_W-1:0] tagc = 8'd1;
  logic [31:0] lfsr = 32'h1234_5678;

  task automatic idle();
    disp_valid = '0; disp_dst_en = '0; disp_dst = '0; disp_tag = '0;
    src_en = '0; src_idx = '0; cmp_valid = '0; cmp_reg = '0; cmp_tag = '0;
  endtask

  task automatic set_src(int k, bit en, int idx);
    src_en[k] = en; src_idx[k*IW +: IW] = IW'(idx);
  endtask

  task automatic set_disp(int g, bit v, bit de, int dst, logic [TAG_W-1:0] t);
    disp_valid[g] = v; disp_dst_en[g] = de; disp_dst[g*IW +: IW] = IW'(dst); disp_tag[g*TAG_W +: TAG_W] = t;
  endtask

  task automatic set_cmp(int c, bit v, int r, logic [TAG_W-1:0] t);
    cmp_valid[c] = v; cmp_reg[c*IW +: IW] = IW'(r); cmp_tag[c*TAG_W +: TAG_W] = t;
  endtask

  task automatic check(string req, int k, bit er, logic [TAG_W-1:0] et);
    n_cmp++;
    if (src_ready[k] !== er || src_tag[k*TAG_W +: TAG_W] !== et) begin
      n_bad++;
      $display("FAIL %s src%0d: got ready=%0b tag=%0d, expected ready=%0b tag=%0d",
               req, k, src_ready[k], src_tag[k*TAG_W +: TAG_W], er, et);
    end
  endtask

  task automatic model_check(string req);
    for (int k = 0; k < NSRC; k++) begin
      automatic int idx = int'(src_idx[k*IW +: IW]);
      automatic bit r = m_rdy[idx];
      automatic logic [TAG_W-1:0] t = m_tag[idx];
      for (int c = 0; c < CMP; c++)
        if (cmp_valid[c] && int'(cmp_reg[c*IW +: IW]) == idx && cmp_tag[c*TAG_W +: TAG_W] == m_tag[idx]) r = 1;
      for (int o = 0; o < k / 2; o++)
        if (disp_valid[o] && disp_dst_en[o] && int'(disp_dst[o*IW +: IW]) == idx) begin
          r = 0; t = disp_tag[o*TAG_W +: TAG_W];
        end
      if (!src_en[k]) r = 1;
      if (r) t = '0;
      check(req, k, r, t);
    end
  endtask

  task automatic step(string req);
    #1 model_check(req);
    @(posedge clk);
    for (int c = 0; c < CMP; c++)
      if (cmp_valid[c] && m_tag[cmp_reg[c*IW +: IW]] == cmp_tag[c*TAG_W +: TAG_W])
        m_rdy[cmp_reg[c*IW +: IW]] = 1;
    for (int g = 0; g < GROUP; g++)
      if (disp_valid[g] && disp_dst_en[g]) begin
        m_rdy[disp_dst[g*IW +: IW]] = 0;
        m_tag[disp_dst[g*IW +: IW]] = disp_tag[g*TAG_W +: TAG_W];
      end
    @(negedge clk);
    idle();
  endtask

  function automatic logic [31:0] nxt(logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_up();
  end

  initial begin
    idle();
    for (int i = 0; i < NREG; i++) begin m_rdy[i] = 1; m_tag[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: every register ready after reset
    for (int r = 0; r < NREG; r++) begin
      set_src(0, 1, r);
      #0.5 check("R1", 0, 1, '0);
    end
    idle();

    // R2: absent operand with a random index
    set_src(1, 0, 33); set_src(3, 0, 77);
    step("R2");

    // R7, R8, R11 in one group
    set_disp(0, 1, 1, 5, 8'd10); set_src(0, 1, 5);
    set_disp(1, 1, 1, 5, 8'd11); set_src(2, 1, 5); set_src(3, 0, 5);
    #1 check("R11", 0, 1, '0); check("R7", 2, 0, 8'd10);
    step("R7");
    set_src(0, 1, 5);
    #1 check("R8", 0, 0, 8'd11);
    step("R8");

    // R6: stale completion
    set_cmp(0, 1, 5, 8'd10); set_src(0, 1, 5);
    #1 check("R6", 0, 0, 8'd11);
    step("R6");
    set_src(0, 1, 5);
    #1 check("R6", 0, 0, 8'd11);
    step("R3");

    // R10 then R5
    set_cmp(1, 1, 5, 8'd11); set_src(1, 1, 5);
    #1 check("R10", 1, 1, '0);
    step("R10");
    set_src(0, 1, 5);
    #1 check("R5", 0, 1, '0);
    step("R5");

    // R4 then R9
    set_disp(0, 1, 1, 7, 8'd12);
    step("R4");
    set_src(0, 1, 7);
    #1 check("R4", 0, 0, 8'd12);
    set_cmp(0, 1, 7, 8'd12); set_disp(1, 1, 1, 7, 8'd13);
    step("R9");
    set_src(0, 1, 7);
    #1 check("R9", 0, 0, 8'd13);
    step("R9");

    // R12: invalid slot ignored
    set_disp(0, 0, 1, 9, 8'd14); set_disp(1, 0, 1, 9, 8'd15);
    step("R12");
    set_src(0, 1, 9);
    #1 check("R12", 0, 1, '0);
    step("R12");
    tagc = 8'd20;

    // R3: long pseudo-random run over eight colliding registers
    for (int n = 0; n < 3000; n++) begin
      for (int g = 0; g < GROUP; g++) begin
        lfsr = nxt(lfsr);
        if (lfsr[0]) begin
          set_disp(g, 1, lfsr[1], int'(lfsr[4:2]), tagc);
          tagc++;
        end else set_disp(g, 0, lfsr[1], int'(lfsr[4:2]), 8'hFF);
      end
      for (int k = 0; k < NSRC; k++) begin
        lfsr = nxt(lfsr);
        set_src(k, lfsr[0] | lfsr[1], int'(lfsr[4:2]));
      end
      for (int c = 0; c < CMP; c++) begin
        lfsr = nxt(lfsr);
        set_cmp(c, lfsr[0], int'(lfsr[3:1]), lfsr[4] ? m_tag[lfsr[3:1]] : lfsr[12:5]);
      end
      step("R3");
    end
    finish_up();
  end
endmodule